// File: doc/BRIEF.md
# Multi-Ring Word Queue Manager with Overflow Redirection

This block keeps a small set of independent circular queues ("rings") of 32-bit words in internal storage. A producer adds a word to a ring by presenting a push with the ring number and the data. A consumer removes the oldest word of a ring by presenting a pop with the ring number. The popped word appears on a registered output one cycle later. Each ring reports its occupancy and drives a level interrupt toward its consumer while it holds at least one word.

A single global overflow-target register names a ring that absorbs pushes aimed at a full ring. If the target is disabled, or is itself full, the push is discarded. The full source ring keeps its pointers, occupancy and contents, and it can still be popped. Per-ring sticky flags record discarded pushes and pops of an empty ring. Writing a 1 to a clear bit resets the matching flag, so software can detect drops even when redirection is off.

Top module: `ring_queue_mgr`

## Requirements
- R1: A push to a ring that has room stores the word in that ring, and the ring's occupancy rises by one at the next clock edge.
- R2: A pop of a non-empty ring returns its oldest word on `pop_data` in the cycle after the pop, in first-in first-out order, and lowers that ring's occupancy by one.
- R3: Each ring's occupancy is reported on its own `CNT_W`-bit field of `occupancy` (ring i at bits i*CNT_W upward) and never exceeds `RING_DEPTH`.
- R4: A push to a full ring, while the overflow target is a ring number below `NUM_RINGS` and that ring has room, is stored in the target ring. The source ring is left unchanged.
- R5: A push to a full ring whose overflow target is also full (including a target equal to the source) is discarded. Both rings keep their occupancy and contents, and later pops return the stored words.
- R6: An overflow-target value of `NUM_RINGS` or above disables redirection, and a push to a full ring is then discarded. The target resets to 16'hFFFF (disabled) and is loaded from `ovf_tgt_wdata` when `ovf_tgt_we` is high.
- R7: A discarded push sets the source ring's bit in `ovf_flag`. The bit stays set until a cycle with the matching `ovf_clr` bit high and no new drop on that ring; a drop in the clearing cycle keeps the bit set.
- R8: A pop of an empty ring returns zero on `pop_data` and leaves that ring's occupancy unchanged. It also sets that ring's sticky `udf_flag` bit, which is cleared through `udf_clr` in the same way as R7.
- R9: `irq[i]` is high exactly while ring i holds at least one word.
- R10: A push and a pop to the same ring in the same cycle are both accepted, and the occupancy stays unchanged; a full ring accepts the push because the pop frees a slot. A push and a pop of an empty ring in the same cycle return zero and set the underflow flag, and the pushed word is stored.
- R11: After reset every ring is empty, all flags and interrupts are low, and `pop_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_en | input | 1 | Push request this cycle |
| push_ring | input | RID_W | Ring addressed by the push |
| push_data | input | DATA_W | Word to push |
| pop_en | input | 1 | Pop request this cycle |
| pop_ring | input | RID_W | Ring addressed by the pop |
| pop_data | output | DATA_W | Word returned by the previous cycle's pop (zero for an empty ring) |
| ovf_tgt_we | input | 1 | Load the global overflow-target register |
| ovf_tgt_wdata | input | 16 | New overflow-target value |
| ovf_clr | input | NUM_RINGS | Write-1 clear of overflow flags |
| udf_clr | input | NUM_RINGS | Write-1 clear of underflow flags |
| occupancy | output | NUM_RINGS*CNT_W | Packed per-ring occupancy |
| irq | output | NUM_RINGS | Per-ring non-empty interrupt |
| ovf_flag | output | NUM_RINGS | Sticky per-ring dropped-push flags |
| udf_flag | output | NUM_RINGS | Sticky per-ring empty-pop flags |

## Verification
Every ring is filled to its depth, pushed past full with redirection disabled, and then drained and popped once more while empty. This separates normal storage from the drop and underflow paths. Every ordered pair of distinct source and target rings is then swept: the source is filled, and the target is loaded through redirected pushes until one more push is dropped. Draining both rings then tells a redirected word from one that overwrote the source. Simultaneous push and pop on full, partial and empty rings, a target equal to the source, and a flag clear that coincides with a new drop cover the remaining orderings.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Circular pointer advance for a ring of the given depth.
  function automatic int ptr_adv(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle given push/pop acceptance.
  function automatic int occ_next(input int occ, input bit inc, input bit dec);
    return occ + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // A target value names a ring only when below the ring count.
  function automatic bit tgt_valid(input int tgt, input int nrings);
    return (tgt >= 0) && (tgt < nrings);
  endfunction

endpackage

// File: rtl/rq_ring.sv
module rq_ring #(
  parameter int DATA_W     = 32,
  parameter int RING_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             rd_en,
  output logic [DATA_W-1:0]                rd_word,
  output logic [$clog2(RING_DEPTH+1)-1:0]  occ,
  output logic                             empty,
  output logic                             has_room
);
  localparam int PTR_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam int CNT_W = $clog2(RING_DEPTH+1);

  logic [DATA_W-1:0] mem [RING_DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic              pop_go;

  assign empty    = (occ == '0);
  assign pop_go   = rd_en && !empty;
  assign has_room = (occ != CNT_W'(RING_DEPTH)) || pop_go;
  assign rd_word  = mem[head_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem[tail_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
    end else begin
      if (wr_en)  tail_q <= PTR_W'(rq_pkg::ptr_adv(int'(tail_q), RING_DEPTH));
      if (pop_go) head_q <= PTR_W'(rq_pkg::ptr_adv(int'(head_q), RING_DEPTH));
      occ <= CNT_W'(rq_pkg::occ_next(int'(occ), wr_en, pop_go));
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(RING_DEPTH)); // R3
  AST_WRITE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> has_room); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> empty); // R8
  AST_PAIR_HOLDS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && wr_en) |=> $stable(occ)); // R10

endmodule

// File: rtl/rq_route.sv
module rq_route #(
  parameter int NUM_RINGS = 4,
  parameter int RID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_en,
  input  logic [RID_W-1:0]     push_ring,
  input  logic [15:0]          ovf_tgt,
  input  logic [NUM_RINGS-1:0] has_room,
  output logic [NUM_RINGS-1:0] wr_en,
  output logic                 drop,
  output logic                 redirect
);
  logic             tgt_ok;
  logic [RID_W-1:0] tgt_id;

  assign tgt_ok = rq_pkg::tgt_valid(int'(ovf_tgt), NUM_RINGS);
  assign tgt_id = ovf_tgt[RID_W-1:0];

  always_comb begin
    wr_en    = '0;
    drop     = 1'b0;
    redirect = 1'b0;
    if (push_en) begin
      if (has_room[push_ring]) begin
        wr_en[push_ring] = 1'b1;
      end else if (tgt_ok && has_room[tgt_id]) begin
        wr_en[tgt_id] = 1'b1;
        redirect      = 1'b1;
      end else begin
        drop = 1'b1;
      end
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R4
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (wr_en == '0)); // R5
  AST_DISABLED_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_tgt >= 16'(NUM_RINGS)) |-> !redirect); // R6

endmodule

// File: rtl/rq_flags.sv
module rq_flags #(
  parameter int NUM_RINGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] ovf_set,
  input  logic [NUM_RINGS-1:0] udf_set,
  input  logic [NUM_RINGS-1:0] ovf_clr,
  input  logic [NUM_RINGS-1:0] udf_clr,
  output logic [NUM_RINGS-1:0] ovf_q,
  output logic [NUM_RINGS-1:0] udf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      udf_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
      udf_q <= (udf_q & ~udf_clr) | udf_set;
    end
  end

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_chk
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]); // R7
    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set[i] |=> ovf_q[i]); // R7
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (udf_q[i] && !udf_clr[i]) |=> udf_q[i]); // R8
  end

endmodule

// File: rtl/ring_queue_mgr.sv
module ring_queue_mgr #(
  parameter int NUM_RINGS  = 4,
  parameter int RING_DEPTH = 4,
  parameter int DATA_W     = 32,
  localparam int RID_W     = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
  localparam int CNT_W     = $clog2(RING_DEPTH+1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_en,
  input  logic [RID_W-1:0]           push_ring,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop_en,
  input  logic [RID_W-1:0]           pop_ring,
  output logic [DATA_W-1:0]          pop_data,
  input  logic                       ovf_tgt_we,
  input  logic [15:0]                ovf_tgt_wdata,
  input  logic [NUM_RINGS-1:0]       ovf_clr,
  input  logic [NUM_RINGS-1:0]       udf_clr,
  output logic [NUM_RINGS*CNT_W-1:0] occupancy,
  output logic [NUM_RINGS-1:0]       irq,
  output logic [NUM_RINGS-1:0]       ovf_flag,
  output logic [NUM_RINGS-1:0]       udf_flag
);
  logic [15:0]          ovf_tgt_q;
  logic [NUM_RINGS-1:0] pop_hit, wr_en, has_room, empty;
  logic [NUM_RINGS-1:0] drop_vec, udf_vec;
  logic [DATA_W-1:0]    rd_word [NUM_RINGS];
  logic                 drop_ev, redirect_ev, empty_pop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_tgt_q <= 16'hFFFF;
    else if (ovf_tgt_we) ovf_tgt_q <= ovf_tgt_wdata;
  end

  always_comb begin
    pop_hit = '0;
    if (pop_en) pop_hit[pop_ring] = 1'b1;
  end

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    logic [CNT_W-1:0] occ_i;
    rq_ring #(.DATA_W(DATA_W), .RING_DEPTH(RING_DEPTH)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[i]),
      .wr_data  (push_data),
      .rd_en    (pop_hit[i]),
      .rd_word  (rd_word[i]),
      .occ      (occ_i),
      .empty    (empty[i]),
      .has_room (has_room[i])
    );
    assign occupancy[i*CNT_W +: CNT_W] = occ_i;
    assign irq[i] = !empty[i];

    AST_IRQ_DROPS_ON_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_hit[i] && occ_i == CNT_W'(1) && !wr_en[i]) |=> !irq[i]); // R9
  end

  rq_route #(.NUM_RINGS(NUM_RINGS), .RID_W(RID_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_en),
    .push_ring (push_ring),
    .ovf_tgt   (ovf_tgt_q),
    .has_room  (has_room),
    .wr_en     (wr_en),
    .drop      (drop_ev),
    .redirect  (redirect_ev)
  );

  assign empty_pop_ev = pop_en && empty[pop_ring];

  always_comb begin
    drop_vec = '0;
    udf_vec  = '0;
    if (drop_ev)      drop_vec[push_ring] = 1'b1;
    if (empty_pop_ev) udf_vec[pop_ring]   = 1'b1;
  end

  rq_flags #(.NUM_RINGS(NUM_RINGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_set (drop_vec),
    .udf_set (udf_vec),
    .ovf_clr (ovf_clr),
    .udf_clr (udf_clr),
    .ovf_q   (ovf_flag),
    .udf_q   (udf_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pop_data <= '0;
    else if (pop_en) pop_data <= empty_pop_ev ? '0 : rd_word[pop_ring];
  end

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty_pop_ev |=> (pop_data == '0)); // R8
  AST_REDIRECT_SRC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_ev |-> (wr_en[push_ring] == 1'b0)); // R4
  AST_DROP_FLAGS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ovf_flag[$past(push_ring)]); // R7

endmodule

// File: tb/tb_ring_queue_mgr.sv
`timescale 1ns/1ps
module tb_ring_queue_mgr;
  localparam int NR = 4;
  localparam int D  = 4;
  localparam int CW = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_en = 1'b0, pop_en = 1'b0, ovf_tgt_we = 1'b0;
  logic [1:0]        push_ring = '0, pop_ring = '0;
  logic [31:0]       push_data = '0;
  logic [15:0]       ovf_tgt_wdata = '0;
  logic [NR-1:0]     ovf_clr = '0, udf_clr = '0;
  logic [31:0]       pop_data;
  logic [NR*CW-1:0]  occupancy;
  logic [NR-1:0]     irq, ovf_flag, udf_flag;

  ring_queue_mgr #(.NUM_RINGS(NR), .RING_DEPTH(D), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_ring(push_ring),
    .push_data(push_data), .pop_en(pop_en), .pop_ring(pop_ring),
    .pop_data(pop_data), .ovf_tgt_we(ovf_tgt_we), .ovf_tgt_wdata(ovf_tgt_wdata),
    .ovf_clr(ovf_clr), .udf_clr(udf_clr), .occupancy(occupancy), .irq(irq),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, seq = 0;
  bit done = 0;
  int mcnt [NR];
  logic [31:0] mq [NR][D];
  logic [NR-1:0] movf = '0, mudf = '0;
  int mtgt = 16'hFFFF;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < NR; i++) begin
      check(occupancy[i*CW +: CW] == CW'(mcnt[i]), {req, " occupancy"}, 32'(occupancy[i*CW +: CW]), 32'(mcnt[i]));
      check(irq[i] == (mcnt[i] != 0), "R9 irq", 32'(irq[i]), 32'(mcnt[i] != 0));
    end
    check(ovf_flag == movf, {req, " R7 ovf_flag"}, 32'(ovf_flag), 32'(movf));
    check(udf_flag == mudf, {req, " R8 udf_flag"}, 32'(udf_flag), 32'(mudf));
  endtask

  // One clock of stimulus; the model predicts the result from the requirements.
  task automatic step(input bit pe, input int pr, input bit qe, input int qr,
                      input logic [NR-1:0] cov, input logic [NR-1:0] cuf, input string req);
    logic [31:0] d, exp_pop;
    bit pop_ok;
    int dest;
    bit room [NR];
    seq++;
    d = 32'hC0DE_0000 + 32'(seq);
    pop_ok = qe && mcnt[qr] > 0;
    for (int i = 0; i < NR; i++) room[i] = (mcnt[i] < D) || (pop_ok && qr == i);
    dest = -1;
    if (pe) begin
      if (room[pr]) dest = pr;
      else if (mtgt < NR && room[mtgt]) dest = mtgt;
    end
    exp_pop = pop_ok ? mq[qr][0] : 32'h0;
    push_en = pe; push_ring = 2'(pr); push_data = d;
    pop_en = qe;  pop_ring = 2'(qr);
    ovf_clr = cov; udf_clr = cuf;
    @(posedge clk); #2;
    push_en = 0; pop_en = 0; ovf_clr = '0; udf_clr = '0;
    movf = movf & ~cov;
    mudf = mudf & ~cuf;
    if (pop_ok) begin
      for (int k = 0; k < D - 1; k++) mq[qr][k] = mq[qr][k+1];
      mcnt[qr]--;
    end else if (qe) mudf[qr] = 1'b1;
    if (dest >= 0) begin mq[dest][mcnt[dest]] = d; mcnt[dest]++; end
    else if (pe) movf[pr] = 1'b1;
    if (qe) check(pop_data == exp_pop, {req, " R2/R8 pop_data"}, pop_data, exp_pop);
    check_state(req);
  endtask

  task automatic set_tgt(input int v);
    ovf_tgt_we = 1; ovf_tgt_wdata = 16'(v);
    @(posedge clk); #2;
    ovf_tgt_we = 0;
    mtgt = v;
  endtask

  task automatic drain(input int r, input string req);
    while (mcnt[r] > 0) step(0, 0, 1, r, '0, '0, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    // R11 reset state
    check(pop_data == 0, "R11 pop_data", pop_data, 0);
    check_state("R11");

    // R1 R3 R6 R2 R8: per ring fill, drop past full with reset target, drain, empty pop
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < D; k++) step(1, r, 0, 0, '0, '0, "R1 R3 fill");
      step(1, r, 0, 0, '0, '0, "R6 drop disabled");
      drain(r, "R2 drain");
      step(0, 0, 1, r, '0, '0, "R8 empty pop");
    end
    step(0, 0, 0, 0, '1, '1, "R7 R8 clear");

    // R4 R5: all ordered source/target pairs
    for (int s = 0; s < NR; s++) begin
      for (int t = 0; t < NR; t++) begin
        if (s == t) continue;
        set_tgt(t);
        for (int k = 0; k < D; k++) step(1, s, 0, 0, '0, '0, "R4 fill src");
        for (int k = 0; k < D; k++) step(1, s, 0, 0, '0, '0, "R4 redirect");
        step(1, s, 0, 0, '0, '0, "R5 both full drop");
        step(0, 0, 1, s, '0, '0, "R5 pop after drop");
        drain(s, "R5 drain src");
        drain(t, "R4 drain tgt");
        step(0, 0, 0, 0, '1, '1, "R7 clear");
      end
    end

    // R5: target equal to source
    set_tgt(2);
    for (int k = 0; k < D; k++) step(1, 2, 0, 0, '0, '0, "R5 fill self");
    step(1, 2, 0, 0, '0, '0, "R5 self target drop");
    // R7: clear coinciding with a new drop keeps flag set
    step(1, 2, 0, 0, 4'b0100, '0, "R7 set wins");
    // R10: push+pop on full ring
    step(1, 2, 1, 2, '0, '0, "R10 full pair");
    drain(2, "R10 drain");
    // R6: non-ring target value below 0xFFFF also disables
    set_tgt(NR);
    for (int k = 0; k < D; k++) step(1, 1, 0, 0, '0, '0, "R6 fill");
    step(1, 1, 0, 0, '0, '0, "R6 out-of-range target");
    drain(1, "R6 drain");
    // R10: partial ring pair, empty ring pair
    step(1, 3, 0, 0, '0, '0, "R10 prep");
    step(1, 3, 1, 3, '0, '0, "R10 partial pair");
    step(1, 0, 1, 0, '0, '0, "R10 empty pair");
    step(0, 0, 0, 0, '0, 4'b0001, "R8 udf clear");
    drain(3, "R10 drain");
    drain(0, "R10 drain");
    // R10 cross-ring: pop frees target slot in the same cycle as a redirect
    set_tgt(1);
    for (int k = 0; k < D; k++) step(1, 0, 0, 0, '0, '0, "R4 fill");
    for (int k = 0; k < D; k++) step(1, 1, 0, 0, '0, '0, "R4 fill tgt");
    step(1, 0, 1, 1, '0, '0, "R4 redirect into popped target");
    drain(0, "R4 drain");
    drain(1, "R4 drain");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule